// File: doc/BRIEF.md
# Flash erase command sequence decoder

This block sits on the write side of a parallel flash bus. It watches each host write cycle, which carries an address, a data byte and a synchronous write strobe. It recognises the six-write unlock, setup, unlock and command patterns that start a whole-array erase or a single-sector erase. When a pattern completes, it sends a one-cycle start pulse to an erase engine, latches the target sector and reports a mode: reading the array, erase running, or erase suspended.

Once an erase is running, the decoder filters commands. A whole-array erase cannot be interrupted by any write. A sector erase responds only to a suspend command, and a suspended erase responds only to a resume command. The erase engine signals completion with a done strobe, and the decoder then returns to array reading and releases the latched sector. A synchronous hardware reset ends any erase or partial sequence at once. The engine does all pre-erase conditioning itself, so the host never issues any write beyond the command sequence.

Top module: `flash_erase_decoder`

## Requirements
- R1: A whole-array erase starts after six strobed writes, given as (address, data): (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x80), (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x10). In the cycle after the sixth write, start_chip is high for exactly one cycle and mode reads 1 (erase running). Mode encoding: 0 = read array, 1 = erase running, 2 = erase suspended.
- R2: A sector erase uses the same first five writes. The sixth write has data 0x30 at any address. It gives a one-cycle start_sector pulse, mode 1, and sector_addr equal to the top SEC_W bits of that write's address.
- R3: A write whose address or data does not match the next expected step returns the decoder to idle. That write is never counted as the first step of a new sequence.
- R4: While a whole-array erase runs, every write is ignored, including data 0xB0 and complete command sequences. The mode stays 1 and no start pulse occurs.
- R5: While a sector erase runs, a write with data 0xB0 (any address) moves the mode to 2. All other writes are ignored.
- R6: While suspended, a write with data 0x30 (any address) returns the mode to 1. All other writes are ignored.
- R7: eng_done while the mode is 1 returns the mode to 0 and clears sector_addr to 0. In mode 0, sector_addr stays 0.
- R8: A high rst forces mode 0, sector_addr 0, both start pulses low, and discards any partial sequence.
- R9: Address and data presented while wr_en is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Write strobe; a cycle is taken on each clock edge where it is high |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | 8 | Write cycle data byte |
| eng_done | input | 1 | Erase engine completion strobe |
| start_chip | output | 1 | One-cycle whole-array erase start |
| start_sector | output | 1 | One-cycle sector erase start |
| sector_addr | output | SEC_W | Latched sector being erased |
| mode | output | 2 | 0 read array, 1 erase running, 2 erase suspended |

## Verification
The hardest states to reach from the ports are the suspended mode and the ignore rules inside a running whole-array erase. Both need a complete six-write pattern first, and purely random writes almost never produce one. The stimulus therefore mixes random single writes with injected full prefixes, which end in a random sixth write (whole-array, sector or garbage). It also emits suspend, resume and done strobes at random. A bench model tracks the expected mode, sector and pulses after every operation. Directed cases cover a mismatch at the setup step, strobe-low sequences and resets in the middle of an erase.

// File: rtl/fed_pkg.sv
package fed_pkg;
  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_BUSY = 2'd1,
    MODE_SUSP = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GOT1, ST_GOT2, ST_GOT3, ST_GOT4, ST_GOT5
  } step_e;

  localparam logic [7:0] D_KEY_A = 8'hAA;
  localparam logic [7:0] D_KEY_B = 8'h55;
  localparam logic [7:0] D_SETUP = 8'h80;
  localparam logic [7:0] D_CHIP  = 8'h10;
  localparam logic [7:0] D_SECT  = 8'h30;
  localparam logic [7:0] D_SUSP  = 8'hB0;
endpackage

// File: rtl/fed_seq.sv
module fed_seq
  import fed_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              armed,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              hit_chip,
  output logic              hit_sector
);
  localparam logic [ADDR_W-1:0] ADR_ODD  = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] ADR_EVEN = ADDR_W'(12'h2AA);

  step_e step_q, step_d;
  logic  at_odd, at_even;

  assign at_odd  = (wr_addr == ADR_ODD);
  assign at_even = (wr_addr == ADR_EVEN);

  always_comb begin
    step_d     = step_q;
    hit_chip   = 1'b0;
    hit_sector = 1'b0;
    if (!armed) begin
      step_d = ST_IDLE;
    end else if (wr_en) begin
      unique case (step_q)
        ST_IDLE: step_d = (at_odd  && wr_data == D_KEY_A) ? ST_GOT1 : ST_IDLE;
        ST_GOT1: step_d = (at_even && wr_data == D_KEY_B) ? ST_GOT2 : ST_IDLE;
        ST_GOT2: step_d = (at_odd  && wr_data == D_SETUP) ? ST_GOT3 : ST_IDLE;
        ST_GOT3: step_d = (at_odd  && wr_data == D_KEY_A) ? ST_GOT4 : ST_IDLE;
        ST_GOT4: step_d = (at_even && wr_data == D_KEY_B) ? ST_GOT5 : ST_IDLE;
        ST_GOT5: begin
          step_d = ST_IDLE;
          if (at_odd && wr_data == D_CHIP) hit_chip = 1'b1;
          else if (wr_data == D_SECT)     hit_sector = 1'b1;
        end
        default: step_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_IDLE;
    else     step_q <= step_d;
  end

  // R3
  disarm_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |=> step_q == ST_IDLE);

  // R9
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !wr_en) |=> step_q == $past(step_q));
endmodule

// File: rtl/fed_mode.sv
module fed_mode
  import fed_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SEC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              hit_chip,
  input  logic              hit_sector,
  input  logic              eng_done,
  output mode_e             mode_q,
  output logic              start_chip,
  output logic              start_sector,
  output logic [SEC_W-1:0]  sector_q
);
  logic whole_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= MODE_READ;
      whole_q      <= 1'b0;
      start_chip   <= 1'b0;
      start_sector <= 1'b0;
      sector_q     <= '0;
    end else begin
      start_chip   <= 1'b0;
      start_sector <= 1'b0;
      unique case (mode_q)
        MODE_READ: begin
          if (hit_chip) begin
            mode_q     <= MODE_BUSY;
            whole_q    <= 1'b1;
            start_chip <= 1'b1;
          end else if (hit_sector) begin
            mode_q       <= MODE_BUSY;
            whole_q      <= 1'b0;
            start_sector <= 1'b1;
            sector_q     <= wr_addr[ADDR_W-1 -: SEC_W];
          end
        end
        MODE_BUSY: begin
          if (eng_done) begin
            mode_q   <= MODE_READ;
            whole_q  <= 1'b0;
            sector_q <= '0;
          end else if (wr_en && !whole_q && wr_data == D_SUSP) begin
            mode_q <= MODE_SUSP;
          end
        end
        MODE_SUSP: begin
          if (wr_en && wr_data == D_SECT) mode_q <= MODE_BUSY;
        end
        default: mode_q <= MODE_READ;
      endcase
    end
  end

  // R1
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(start_chip && start_sector));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start_chip || start_sector) |-> mode_q == MODE_BUSY);

  // R4
  whole_no_susp_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_BUSY && whole_q) |=> mode_q != MODE_SUSP);

  // R6
  resume_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SUSP && wr_en && wr_data == D_SECT) |=> mode_q == MODE_BUSY);

  // R7
  read_unlatched_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q == MODE_READ |-> sector_q == '0);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (mode_q == MODE_READ && !start_chip && !start_sector));
endmodule

// File: rtl/flash_erase_decoder.sv
module flash_erase_decoder
  import fed_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SEC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              eng_done,
  output logic              start_chip,
  output logic              start_sector,
  output logic [SEC_W-1:0]  sector_addr,
  output logic [1:0]        mode
);
  mode_e mode_w;
  logic  hit_chip, hit_sector;

  fed_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .armed     (mode_w == MODE_READ),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .hit_chip  (hit_chip),
    .hit_sector(hit_sector)
  );

  fed_mode #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_mode (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .hit_chip    (hit_chip),
    .hit_sector  (hit_sector),
    .eng_done    (eng_done),
    .mode_q      (mode_w),
    .start_chip  (start_chip),
    .start_sector(start_sector),
    .sector_q    (sector_addr)
  );

  assign mode = mode_w;
endmodule

// File: tb/flash_erase_decoder_bench.sv
module flash_erase_decoder_bench;
  localparam int ADDR_W = 12;
  localparam int SEC_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              eng_done = 1'b0;
  logic              start_chip, start_sector;
  logic [SEC_W-1:0]  sector_addr;
  logic [1:0]        mode;

  flash_erase_decoder #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_flash_erase_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_done(eng_done), .start_chip(start_chip), .start_sector(start_sector),
    .sector_addr(sector_addr), .mode(mode)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model state
  int              exp_mode = 0;
  bit              exp_whole = 0;
  logic [SEC_W-1:0] exp_sec = '0;
  bit              exp_sc = 0, exp_ss = 0;
  int              step = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "mode", int'(mode), exp_mode);
    chk(req, "sector_addr", int'(sector_addr), int'(exp_sec));
    chk(req, "start_chip", int'(start_chip), int'(exp_sc));
    chk(req, "start_sector", int'(start_sector), int'(exp_ss));
  endtask

  function automatic void ref_write(logic [ADDR_W-1:0] a, logic [7:0] d);
    exp_sc = 0;
    exp_ss = 0;
    case (exp_mode)
      0: begin
        case (step)
          0: step = (a == 12'h555 && d == 8'hAA) ? 1 : 0;
          1: step = (a == 12'h2AA && d == 8'h55) ? 2 : 0;
          2: step = (a == 12'h555 && d == 8'h80) ? 3 : 0;
          3: step = (a == 12'h555 && d == 8'hAA) ? 4 : 0;
          4: step = (a == 12'h2AA && d == 8'h55) ? 5 : 0;
          default: begin
            step = 0;
            if (a == 12'h555 && d == 8'h10) begin
              exp_mode = 1; exp_whole = 1; exp_sc = 1;
            end else if (d == 8'h30) begin
              exp_mode = 1; exp_whole = 0; exp_ss = 1;
              exp_sec = a[ADDR_W-1 -: SEC_W];
            end
          end
        endcase
      end
      1: if (!exp_whole && d == 8'hB0) exp_mode = 2;
      default: if (d == 8'h30) exp_mode = 1;
    endcase
  endfunction

  task automatic do_write(logic [ADDR_W-1:0] a, logic [7:0] d, string req);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    ref_write(a, d);
    check_all(req);
  endtask

  task automatic idle_drive(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b0; wr_addr = a; wr_data = d;
    @(negedge clk);
    exp_sc = 0; exp_ss = 0;
    check_all("R9");
  endtask

  task automatic pulse_done(string req);
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    exp_sc = 0; exp_ss = 0;
    if (exp_mode == 1) begin
      exp_mode = 0; exp_whole = 0; exp_sec = '0;
    end
    check_all(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_mode = 0; exp_whole = 0; exp_sec = '0; exp_sc = 0; exp_ss = 0; step = 0;
    check_all("R8");
  endtask

  task automatic prefix(string req);
    do_write(12'h555, 8'hAA, req);
    do_write(12'h2AA, 8'h55, req);
    do_write(12'h555, 8'h80, req);
    do_write(12'h555, 8'hAA, req);
    do_write(12'h2AA, 8'h55, req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R8");

    // R1 whole-array erase, then R4 ignore, then R7 done
    prefix("R1");
    do_write(12'h555, 8'h10, "R1");
    do_write(12'h123, 8'hB0, "R4");
    do_write(12'h555, 8'h30, "R4");
    prefix("R4");
    do_write(12'hA00, 8'h30, "R4");
    pulse_done("R7");

    // R2 sector erase, R5 suspend, R6 resume, R7 done
    prefix("R2");
    do_write(12'hA23, 8'h30, "R2");
    do_write(12'h555, 8'hAA, "R5");
    do_write(12'h555, 8'h10, "R5");
    do_write(12'h0F0, 8'hB0, "R5");
    do_write(12'h555, 8'h10, "R6");
    do_write(12'h555, 8'hB0, "R6");
    pulse_done("R6");
    do_write(12'h777, 8'h30, "R6");
    pulse_done("R7");

    // R3 mismatch at setup step, the mismatching write not a new start
    do_write(12'h555, 8'hAA, "R3");
    do_write(12'h2AA, 8'h55, "R3");
    do_write(12'h555, 8'hAA, "R3");
    do_write(12'h2AA, 8'h55, "R3");
    do_write(12'h555, 8'h80, "R3");
    do_write(12'h555, 8'hAA, "R3");
    do_write(12'h2AA, 8'h55, "R3");
    do_write(12'h555, 8'h10, "R3");

    // R9 strobe low
    idle_drive(12'h555, 8'hAA);
    idle_drive(12'h2AA, 8'h55);
    idle_drive(12'h555, 8'h80);
    idle_drive(12'h555, 8'hAA);
    idle_drive(12'h2AA, 8'h55);
    idle_drive(12'h555, 8'h10);

    // R8 reset mid-erase and mid-sequence
    prefix("R2");
    do_write(12'hF55, 8'h30, "R2");
    do_reset();
    prefix("R8");
    do_reset();
    do_write(12'h555, 8'h10, "R8");

    // constrained random mix
    for (int i = 0; i < 2500; i++) begin
      int r;
      r = int'($urandom % 10);
      if (i % 500 == 499) do_reset();
      else if (r < 2) begin
        int k;
        prefix("R1/R2");
        k = int'($urandom % 3);
        if (k == 0)      do_write(12'h555, 8'h10, "R1");
        else if (k == 1) do_write(ADDR_W'($urandom), 8'h30, "R2");
        else             do_write(ADDR_W'($urandom), 8'($urandom), "R3");
      end
      else if (r == 2) pulse_done("R7");
      else if (r == 3) do_write(ADDR_W'($urandom), 8'hB0, "R5");
      else if (r == 4) do_write(ADDR_W'($urandom), 8'h30, "R6");
      else begin
        int p;
        p = int'($urandom % 5);
        case (p)
          0: do_write(12'h555, 8'hAA, "R3");
          1: do_write(12'h2AA, 8'h55, "R3");
          2: do_write(12'h555, 8'h80, "R3");
          3: do_write(12'h555, 8'h10, "R3");
          default: do_write(ADDR_W'($urandom), 8'($urandom), "R3");
        endcase
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule